// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches the input pins of one GPIO port (up to 32 pins) and turns selected pin conditions into interrupt requests. Each pin can be configured to detect either a level or a single edge. A polarity bit chooses the active sense: high level or rising edge, or low level or falling edge. Both edges together are not available.

An edge is caught in a sticky latch that stays set until software writes a 1 for that pin to the end-of-interrupt address. A level is never latched, so its status follows the pin. Enable and mask are separate bits. A pin that is enabled but masked shows up in the raw status and stays out of the masked status and the combined interrupt line.

Each pin can be routed through an optional debounce filter. Each pin also has a synchronisation-select bit. When that bit is set, level detection uses the two-flop synchronised pin. When it is clear, level detection uses the raw pin directly. Software drives the block through a simple write strobe with an address, and reads it back through a combinational read port.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset the mask register reads all ones, the enable register reads zero, the synchronisation-select register reads all ones, the raw status reads zero and `irq_out` is 0.
- R2: In level mode (type bit 0), an enabled pin is active while the pin equals its polarity bit (polarity 1 = active high, 0 = active low). Its status follows the pin with no latching, and an end-of-interrupt write has no effect on it.
- R3: In edge mode (type bit 1) with polarity 1, a rising edge on an enabled pin sets its status bit, which stays set after the pin returns low. A falling edge sets nothing.
- R4: In edge mode with polarity 0, a falling edge sets the latched status. A rising edge sets nothing.
- R5: Writing a 1 to a pin's bit at the end-of-interrupt address (5) clears that pin's latched edge. Bits written as 0 leave their latches unchanged.
- R6: A pin with its mask bit set still appears in the raw status (address 8) but is 0 in the masked status (address 9). A pin with its enable bit clear is 0 in both.
- R7: `irq_out` is the OR of all masked status bits.
- R8: With the pin's debounce bit set, a pin pulse shorter than one debounce tick period (DB_DIV clocks) is ignored. A pin value held for DB_HOLD consecutive ticks is accepted.
- R9: With the synchronisation-select bit clear, a level-mode status reflects a pin change in the same cycle. With it set, the change appears after exactly two rising clock edges.
- R10: Writing the value read from the masked status back to the end-of-interrupt address clears every pending edge interrupt it reports.

Register addresses: 0 enable, 1 mask, 2 type, 3 polarity, 4 debounce enable, 5 end-of-interrupt (write only), 6 synchronisation select, 8 raw status, 9 masked status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | NPIN | Asynchronous GPIO input pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | NPIN | Write data, one bit per pin |
| rd_addr | input | 4 | Read address |
| rd_data | output | NPIN | Combinational read data |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is the debounce rejection. A glitch must reach the synchronised input for less than one tick period, so the tick divider can sample it at most once. The stimulus for this drives a pulse of a single clock cycle on a debounced edge-mode pin, waits several tick periods, and confirms that no edge was latched. It then holds the pin for well beyond DB_HOLD ticks to show that the filter still passes a real change. The synchronisation-select timing is also checked on exact edges: the bench samples the status half a cycle, one cycle and two cycles after a pin change.

// File: rtl/gpio_irq_pkg.sv
// Package: register address map for the GPIO interrupt detector.
// Assumes a 4-bit address space; unused addresses read as zero.
package gpio_irq_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_ENABLE = 4'd0,
        REG_MASK   = 4'd1,
        REG_TYPE   = 4'd2,
        REG_POL    = 4'd3,
        REG_DBNC   = 4'd4,
        REG_EOI    = 4'd5,
        REG_SYNC   = 4'd6,
        REG_RAW    = 4'd8,
        REG_STAT   = 4'd9
    } reg_addr_e;
endpackage

// File: rtl/gpio_sync2.sv
// Module: two-flop synchroniser, one chain per pin.
// Assumes each pin is an independent asynchronous signal (no bus coherence).
module gpio_sync2 #(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] d_async,
    output logic [NPIN-1:0] q_sync
);
    logic [NPIN-1:0] stage1_q;

    // Two register stages to resolve metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            q_sync   <= '0;
        end else begin
            stage1_q <= d_async;
            q_sync   <= stage1_q;
        end
    end
endmodule

// File: rtl/gpio_debounce.sv
// Module: per-pin debounce filter driven by a shared divided tick.
// A new value is accepted only after it differs from the current output on
// HOLD consecutive ticks; any tick that sees agreement restarts the count.
// Assumes input is already synchronised to clk.
module gpio_debounce #(
    parameter int NPIN = 8,
    parameter int DIV  = 4,
    parameter int HOLD = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] d_in,
    output logic [NPIN-1:0] q_out
);
    localparam int DIV_W  = (DIV  > 1) ? $clog2(DIV)  : 1;
    localparam int HOLD_W = (HOLD > 1) ? $clog2(HOLD) : 1;

    logic [DIV_W-1:0] div_q;
    logic             tick;

    // Free-running divider producing a one-cycle tick every DIV clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else if (div_q == DIV_W'(DIV - 1)) div_q <= '0;
        else div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == DIV_W'(DIV - 1));

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        logic [HOLD_W-1:0] cnt_q;

        // Count ticks of disagreement; commit the new value after HOLD of them.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q    <= '0;
                q_out[g] <= 1'b0;
            end else if (tick) begin
                if (d_in[g] == q_out[g]) begin
                    cnt_q <= '0;
                end else if (cnt_q == HOLD_W'(HOLD - 1)) begin
                    cnt_q    <= '0;
                    q_out[g] <= d_in[g];
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/gpio_detect.sv
// Module: per-pin level/edge detection with sticky edge latches.
// Edge detection always uses the clocked (synchronised or debounced) value;
// level detection may use the raw pin when synchronisation is deselected.
// A new edge in the same cycle as an end-of-interrupt clear wins.
module gpio_detect #(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_raw,
    input  logic [NPIN-1:0] pin_s,
    input  logic [NPIN-1:0] pin_db,
    input  logic [NPIN-1:0] en,
    input  logic [NPIN-1:0] typ,
    input  logic [NPIN-1:0] pol,
    input  logic [NPIN-1:0] dbnc,
    input  logic [NPIN-1:0] sync_sel,
    input  logic [NPIN-1:0] eoi_clr,
    output logic [NPIN-1:0] raw_stat,
    output logic [NPIN-1:0] latch_q,
    output logic [NPIN-1:0] edge_evt
);
    logic [NPIN-1:0] filt;
    logic [NPIN-1:0] lvl_src;
    logic [NPIN-1:0] prev_q;
    logic [NPIN-1:0] rise;
    logic [NPIN-1:0] fall;

    // Select the clocked source and the level source per pin.
    always_comb begin
        for (int i = 0; i < NPIN; i++) begin
            filt[i]    = dbnc[i] ? pin_db[i] : pin_s[i];
            lvl_src[i] = dbnc[i] ? pin_db[i] : (sync_sel[i] ? pin_s[i] : pin_raw[i]);
        end
    end

    // Remember the previous clocked sample for edge extraction.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= filt;
    end

    assign rise     = filt & ~prev_q;
    assign fall     = ~filt & prev_q;
    assign edge_evt = en & typ & ((pol & rise) | (~pol & fall));

    // Sticky edge latch: set by an event, cleared by end-of-interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= (latch_q & ~eoi_clr) | edge_evt;
    end

    assign raw_stat = en & ((typ & latch_q) | (~typ & ~(lvl_src ^ pol)));
endmodule

// File: rtl/gpio_irq_detect.sv
// Module: top of the GPIO interrupt detector. Holds the configuration
// registers, routes pins through synchroniser/debounce/detection and
// produces raw status, masked status and a combined interrupt.
// Assumes a single write strobe per cycle and combinational reads.
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPIN    = 8,
    parameter int DB_DIV  = 4,
    parameter int DB_HOLD = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   pin_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NPIN-1:0]   wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [NPIN-1:0]   rd_data,
    output logic              irq_out
);
    logic [NPIN-1:0] en_q, mask_q, type_q, pol_q, dbnc_q, sync_q;
    logic [NPIN-1:0] eoi_clr;
    logic [NPIN-1:0] pin_s, pin_db;
    logic [NPIN-1:0] raw_stat, stat;
    logic [NPIN-1:0] latch_q, edge_evt;

    // Configuration register writes; reset leaves every pin masked and off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            mask_q <= '1;
            type_q <= '0;
            pol_q  <= '0;
            dbnc_q <= '0;
            sync_q <= '1;
        end else if (wr_en) begin
            case (wr_addr)
                REG_ENABLE: en_q   <= wr_data;
                REG_MASK:   mask_q <= wr_data;
                REG_TYPE:   type_q <= wr_data;
                REG_POL:    pol_q  <= wr_data;
                REG_DBNC:   dbnc_q <= wr_data;
                REG_SYNC:   sync_q <= wr_data;
                default: ;
            endcase
        end
    end

    assign eoi_clr = (wr_en && wr_addr == REG_EOI) ? wr_data : '0;

    gpio_sync2 #(.NPIN(NPIN)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (pin_s)
    );

    gpio_debounce #(.NPIN(NPIN), .DIV(DB_DIV), .HOLD(DB_HOLD)) u_dbnc (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_s),
        .q_out (pin_db)
    );

    gpio_detect #(.NPIN(NPIN)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (pin_in),
        .pin_s    (pin_s),
        .pin_db   (pin_db),
        .en       (en_q),
        .typ      (type_q),
        .pol      (pol_q),
        .dbnc     (dbnc_q),
        .sync_sel (sync_q),
        .eoi_clr  (eoi_clr),
        .raw_stat (raw_stat),
        .latch_q  (latch_q),
        .edge_evt (edge_evt)
    );

    assign stat    = raw_stat & ~mask_q;
    assign irq_out = |stat;

    // Read multiplexer.
    always_comb begin
        case (rd_addr)
            REG_ENABLE: rd_data = en_q;
            REG_MASK:   rd_data = mask_q;
            REG_TYPE:   rd_data = type_q;
            REG_POL:    rd_data = pol_q;
            REG_DBNC:   rd_data = dbnc_q;
            REG_SYNC:   rd_data = sync_q;
            REG_RAW:    rd_data = raw_stat;
            REG_STAT:   rd_data = stat;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_detect_chk.sv
// Checker: temporal properties of the GPIO interrupt detector, bound to the top.
module gpio_irq_detect_chk #(
    parameter int NPIN = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [3:0]      wr_addr,
    input logic [NPIN-1:0] wr_data,
    input logic [3:0]      rd_addr,
    input logic [NPIN-1:0] rd_data,
    input logic            irq_out,
    input logic [NPIN-1:0] latch_q,
    input logic [NPIN-1:0] edge_evt
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq_out); // R1

    AST_LATCH_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((latch_q & ~$past(latch_q) & ~$past(edge_evt)) == '0)); // R3

    AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 4'd5) |=> ((latch_q & $past(wr_data) & ~$past(edge_evt)) == '0)); // R5

    AST_MASK_ALL_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 4'd1 && (&wr_data)) |=> !irq_out); // R6

    AST_IRQ_IS_OR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 4'd9) |-> (irq_out == (|rd_data))); // R7
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NPIN(NPIN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .irq_out  (irq_out),
    .latch_q  (latch_q),
    .edge_evt (edge_evt)
);

// File: tb/sim_gpio_irq_detect.sv
// Directed bench for the GPIO interrupt detector.
module sim_gpio_irq_detect;
    localparam int CLK_PERIOD = 10;
    localparam int NPIN = 8;
    localparam int DB_DIV = 4;
    localparam int DB_HOLD = 4;

    localparam logic [3:0] A_EN = 4'd0, A_MASK = 4'd1, A_TYPE = 4'd2, A_POL = 4'd3,
                           A_DBNC = 4'd4, A_EOI = 4'd5, A_SYNC = 4'd6,
                           A_RAW = 4'd8, A_STAT = 4'd9;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NPIN-1:0] pin_in = '0;
    logic            wr_en = 1'b0;
    logic [3:0]      wr_addr = '0;
    logic [NPIN-1:0] wr_data = '0;
    logic [3:0]      rd_addr = '0;
    logic [NPIN-1:0] rd_data;
    logic            irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    gpio_irq_detect #(.NPIN(NPIN), .DB_DIV(DB_DIV), .DB_HOLD(DB_HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [NPIN-1:0] act, input logic [NPIN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pin_in = '0; wr_en = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(1);
    endtask

    task automatic wr(input logic [3:0] a, input logic [NPIN-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [NPIN-1:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [NPIN-1:0] v;
        do_reset();
        rd(A_MASK, v); chk("R1 mask", v, '1);
        rd(A_EN, v);   chk("R1 enable", v, '0);
        rd(A_SYNC, v); chk("R1 sync", v, '1);
        rd(A_RAW, v);  chk("R1 raw", v, '0);
        chk("R1 irq", {{(NPIN-1){1'b0}}, irq_out}, '0);
    endtask

    task automatic t_level();
        logic [NPIN-1:0] v;
        do_reset();
        wr(A_POL, 8'h01);          // pin0 active high, pin1 active low
        wr(A_EN, 8'h03);
        wr(A_MASK, 8'hFC);
        wait_clk(3);
        rd(A_STAT, v); chk("R2 idle levels", v, 8'h02);
        pin_in[0] = 1'b1; pin_in[1] = 1'b1;
        wait_clk(3);
        rd(A_STAT, v); chk("R2 high levels", v, 8'h01);
        wr(A_EOI, 8'hFF);
        rd(A_STAT, v); chk("R2 eoi no effect on level", v, 8'h01);
        pin_in[0] = 1'b0;
        wait_clk(3);
        rd(A_STAT, v); chk("R2 level not latched", v, 8'h00);
    endtask

    task automatic t_rise();
        logic [NPIN-1:0] v;
        do_reset();
        pin_in[3] = 1'b1;
        wait_clk(3);
        wr(A_TYPE, 8'h0C); wr(A_POL, 8'h0C); wr(A_EN, 8'h0C); wr(A_MASK, 8'h00);
        wait_clk(3);
        pin_in[2] = 1'b1; pin_in[3] = 1'b0;
        wait_clk(5);
        rd(A_STAT, v); chk("R3 rising latched, falling ignored", v, 8'h04);
        pin_in[2] = 1'b0;
        wait_clk(5);
        rd(A_STAT, v); chk("R3 latch holds after pin drops", v, 8'h04);
        chk("R7 irq with pending edge", {{(NPIN-1){1'b0}}, irq_out}, 8'h01);
    endtask

    task automatic t_fall();
        logic [NPIN-1:0] v;
        do_reset();
        pin_in[4] = 1'b1;
        wait_clk(3);
        wr(A_TYPE, 8'h30); wr(A_POL, 8'h00); wr(A_EN, 8'h30); wr(A_MASK, 8'h00);
        wait_clk(3);
        rd(A_STAT, v); chk("R4 no spurious edge", v, 8'h00);
        pin_in[4] = 1'b0; pin_in[5] = 1'b1;
        wait_clk(5);
        rd(A_STAT, v); chk("R4 falling latched, rising ignored", v, 8'h10);
    endtask

    task automatic t_eoi();
        logic [NPIN-1:0] v;
        do_reset();
        wr(A_TYPE, 8'h03); wr(A_POL, 8'h03); wr(A_EN, 8'h03); wr(A_MASK, 8'h00);
        pin_in[1:0] = 2'b11;
        wait_clk(5);
        rd(A_STAT, v); chk("R5 both latched", v, 8'h03);
        wr(A_EOI, 8'h00);
        rd(A_STAT, v); chk("R5 zero write keeps latches", v, 8'h03);
        wr(A_EOI, 8'h01);
        rd(A_STAT, v); chk("R5 one clears only pin0", v, 8'h02);
        pin_in[1:0] = 2'b00;
        wait_clk(3);
        pin_in[1:0] = 2'b11;
        wait_clk(5);
        rd(A_STAT, v); chk("R10 pending before ack", v, 8'h03);
        wr(A_EOI, v);
        rd(A_STAT, v); chk("R10 write-back clears all", v, 8'h00);
        chk("R7 irq low after ack", {{(NPIN-1){1'b0}}, irq_out}, 8'h00);
    endtask

    task automatic t_mask();
        logic [NPIN-1:0] v;
        do_reset();
        wr(A_TYPE, 8'h41); wr(A_POL, 8'h41); wr(A_EN, 8'h01);
        pin_in[0] = 1'b1; pin_in[6] = 1'b1;
        wait_clk(5);
        rd(A_RAW, v);  chk("R6 masked pin in raw, disabled pin absent", v, 8'h01);
        rd(A_STAT, v); chk("R6 masked pin hidden", v, 8'h00);
        chk("R7 irq low when masked", {{(NPIN-1){1'b0}}, irq_out}, 8'h00);
        wr(A_MASK, 8'hFE);
        rd(A_STAT, v); chk("R6 unmasked pin shown", v, 8'h01);
        chk("R7 irq high when unmasked", {{(NPIN-1){1'b0}}, irq_out}, 8'h01);
    endtask

    task automatic t_debounce();
        logic [NPIN-1:0] v;
        do_reset();
        wr(A_DBNC, 8'h10); wr(A_TYPE, 8'h10); wr(A_POL, 8'h10);
        wr(A_EN, 8'h10); wr(A_MASK, 8'h00);
        wait_clk(3);
        pin_in[4] = 1'b1;
        wait_clk(1);
        pin_in[4] = 1'b0;
        wait_clk(DB_DIV * DB_HOLD * 3);
        rd(A_STAT, v); chk("R8 short glitch rejected", v, 8'h00);
        pin_in[4] = 1'b1;
        wait_clk(DB_DIV * (DB_HOLD + 2) + 6);
        rd(A_STAT, v); chk("R8 held value accepted", v, 8'h10);
    endtask

    task automatic t_sync();
        logic [NPIN-1:0] v;
        do_reset();
        wr(A_POL, 8'h20); wr(A_EN, 8'h20); wr(A_MASK, 8'h00); wr(A_SYNC, 8'h00);
        rd_addr = A_STAT;
        @(negedge clk);
        pin_in[5] = 1'b1;
        rd(A_STAT, v); chk("R9 unsynchronised level immediate", v, 8'h20);
        pin_in[5] = 1'b0;
        wait_clk(3);
        wr(A_SYNC, 8'hFF);
        wait_clk(2);
        pin_in[5] = 1'b1;
        rd(A_STAT, v); chk("R9 sync: not yet", v, 8'h00);
        wait_clk(1);
        rd(A_STAT, v); chk("R9 sync: one edge later", v, 8'h00);
        wait_clk(1);
        rd(A_STAT, v); chk("R9 sync: two edges later", v, 8'h20);
    endtask

    initial begin
        wait_clk(2);
        t_reset();
        t_level();
        t_rise();
        t_fall();
        t_eoi();
        t_mask();
        t_debounce();
        t_sync();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule